// File: doc/BRIEF.md
# Modem Clock Output Selector

This block produces the signal for a modem's clock output pin. It is clocked by an 11.0592 MHz reference. A control input picks the source. One source is the reference itself, passed straight through. The other is a divided clock at sixteen times the current data rate. The divided clock exists only for the two phase-modulated modes. When the modulation mode is frequency-shift keying, or the mode code is the reserved one, the pin keeps the reference echo even if the control input asks for the divided clock.

A change of mode, rate option or control bit never cuts a pulse short. The selector flop works on the falling edge of the reference and moves only while the divided clock is low. A new rate is loaded only once the divided clock is low, and the counter then starts again from zero. A soft reset sends the pin back to the reference echo within two reference cycles and clears the divider.

Top module: `modem_clkout_gen`

## Requirements
- R1: With `clk_ctrl` = 0, `clk_out` follows `clk_ref` in every mode and for either rate option.
- R2: With `clk_ctrl` = 1 and `mod_mode` = 2'b10 (QAM, 2400 bit/s), `clk_out` is high for 144 reference cycles and low for 144, a division by 288. `rate_opt` has no effect in this mode.
- R3: With `clk_ctrl` = 1 and `mod_mode` = 2'b01 (DPSK), `clk_out` has half periods of 288 reference cycles when `rate_opt` = 0 (1200 bit/s). When `rate_opt` = 1 (600 bit/s) the half periods are 576 cycles.
- R4: With `clk_ctrl` = 1 and `mod_mode` = 2'b00 (FSK) or the reserved code 2'b11, `clk_out` follows `clk_ref` and the divider stays idle.
- R5: Once `soft_rst` has been high at two rising reference edges, `clk_out` follows `clk_ref`. It keeps doing so for as long as `soft_rst` stays high, whatever the other inputs are.
- R6: Outside reset, every high pulse on `clk_out` lasts either half a reference period or exactly the half period of one of the divided rates. Every low pulse lasts at least half a reference period.
- R7: Suppose a new divided rate is applied while the divided clock is low. The divider restarts from zero, and the next rising edge of `clk_out` comes exactly H_new reference cycles after the first rising reference edge that sees the new setting.
- R8: Suppose the rate changes while the divided clock is high. That high pulse still ends at its old width, and the next full high pulse has the new width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | 11.0592 MHz reference clock, also the echo source |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| clk_ctrl | input | 1 | 0: echo the reference; 1: request the 16x data-rate clock |
| mod_mode | input | 2 | 2'b10 QAM, 2'b01 DPSK, 2'b00 FSK, 2'b11 reserved |
| rate_opt | input | 1 | DPSK rate option: 0 is 1200 bit/s, 1 is 600 bit/s |
| clk_out | output | 1 | Clock output pin signal |

## Verification
The hardest situations to reach from the ports are the rate changes that land in a known phase of the divided clock. One is a change made at the very start of a low phase, which checks that the counter restarts. The other is a change made just after a rising edge, which checks that a high pulse is never truncated. The bench reaches both by watching `clk_out` at each falling reference edge. It applies the new setting in the same low half-cycle in which it sees the divided edge it is waiting for. A time-based monitor measures the width of every pulse on the pin. Random mode, option and control sequences from a fixed seed cover the other transitions.

// File: rtl/clkout_pkg.sv
`timescale 1ns/1ps
package clkout_pkg;
   typedef enum logic [1:0] {
      MODE_FSK  = 2'b00,
      MODE_DPSK = 2'b01,
      MODE_QAM  = 2'b10,
      MODE_RSVD = 2'b11
   } mod_mode_e;
endpackage

// File: rtl/clkout_rate_sel.sv
`timescale 1ns/1ps
module clkout_rate_sel #(
   parameter int HALF_W = 10,
   parameter int H_FAST = 144,
   parameter int H_MID  = 288,
   parameter int H_SLOW = 576
) (
   input  logic              clk_ctrl,
   input  logic [1:0]        mod_mode,
   input  logic              rate_opt,
   output logic              want_div,
   output logic [HALF_W-1:0] half_sel
);
   import clkout_pkg::*;

   localparam logic [HALF_W-1:0] HF = HALF_W'(H_FAST);
   localparam logic [HALF_W-1:0] HM = HALF_W'(H_MID);
   localparam logic [HALF_W-1:0] HS = HALF_W'(H_SLOW);

   always_comb begin
      want_div = 1'b0;
      half_sel = '0;
      if (clk_ctrl) begin
         unique case (mod_mode_e'(mod_mode))
            MODE_QAM: begin
               want_div = 1'b1;
               half_sel = HF;
            end
            MODE_DPSK: begin
               want_div = 1'b1;
               half_sel = rate_opt ? HS : HM;
            end
            default: begin
               want_div = 1'b0;
               half_sel = '0;
            end
         endcase
      end
   end
endmodule

// File: rtl/clkout_divider.sv
`timescale 1ns/1ps
module clkout_divider #(
   parameter int HALF_W = 10
) (
   input  logic              clk,
   input  logic              soft_rst,
   input  logic              want_div,
   input  logic [HALF_W-1:0] half_req,
   input  logic              use_div,
   output logic              div_q,
   output logic [HALF_W-1:0] key_q
);
   localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

   logic [HALF_W-1:0] key_n;
   logic [HALF_W-1:0] cnt_q;

   // keep the old rate running while the selector still drives it out
   always_comb begin
      if (want_div)     key_n = half_req;
      else if (use_div) key_n = key_q;
      else              key_n = '0;
   end

   always_ff @(posedge clk) begin
      if (soft_rst) begin
         key_q <= '0;
         cnt_q <= '0;
         div_q <= 1'b0;
      end else if ((key_n != key_q) && !div_q) begin
         key_q <= key_n;
         cnt_q <= '0;
         div_q <= 1'b0;
      end else if (key_q == '0) begin
         cnt_q <= '0;
         div_q <= 1'b0;
      end else if (cnt_q == key_q - ONE) begin
         cnt_q <= '0;
         div_q <= ~div_q;
      end else begin
         cnt_q <= cnt_q + ONE;
      end
   end

   // R7: a newly loaded rate starts from a cleared counter, output low
   a_r7_restart_zero: assert property (@(posedge clk) disable iff (soft_rst)
      (key_q != $past(key_q)) |-> (cnt_q == '0 && !div_q));

   // R8: the divided clock flips only at the terminal count of the rate in force
   a_r8_toggle_terminal: assert property (@(posedge clk) disable iff (soft_rst)
      !$stable(div_q) |-> ($past(cnt_q) == $past(key_q) - ONE));

   // R4: with no request and the pin on echo, the divider goes idle
   a_r4_idle_when_echo: assert property (@(posedge clk) disable iff (soft_rst)
      (!want_div && !use_div && !div_q) |=> (key_q == '0));
endmodule

// File: rtl/clkout_switch.sv
`timescale 1ns/1ps
module clkout_switch (
   input  logic clk,
   input  logic soft_rst,
   input  logic want_div,
   input  logic div_q,
   output logic use_div,
   output logic clk_out
);
   // falling edge: reference is low; divided clock only moves on rising edges
   always_ff @(negedge clk) begin
      if (soft_rst)
         use_div <= 1'b0;
      else if ((want_div != use_div) && !div_q)
         use_div <= want_div;
   end

   assign clk_out = use_div ? div_q : clk;

   // R6: the source moves only while the divided clock is low
   a_r6_switch_when_low: assert property (@(negedge clk) disable iff (soft_rst)
      (!$stable(use_div) && !$past(soft_rst)) |-> !$past(div_q));

   // R5: a soft reset seen at a falling edge leaves the pin on echo
   a_r5_reset_echo: assert property (@(negedge clk)
      $past(soft_rst) |-> !use_div);
endmodule

// File: rtl/modem_clkout_gen.sv
`timescale 1ns/1ps
module modem_clkout_gen #(
   parameter int REF_HZ     = 11_059_200,
   parameter int OVERSAMPLE = 16,
   parameter int FAST_BPS   = 2400
) (
   input  logic       clk_ref,
   input  logic       soft_rst,
   input  logic       clk_ctrl,
   input  logic [1:0] mod_mode,
   input  logic       rate_opt,
   output logic       clk_out
);
   localparam int BASE_DIV = REF_HZ / (OVERSAMPLE * FAST_BPS);
   localparam int H_FAST   = BASE_DIV / 2;
   localparam int H_MID    = BASE_DIV;
   localparam int H_SLOW   = BASE_DIV * 2;
   localparam int HALF_W   = $clog2(H_SLOW + 1);

   if (REF_HZ % (OVERSAMPLE * FAST_BPS) != 0) begin : g_bad_ratio
      $error("reference is not a whole multiple of the fastest 16x rate");
   end
   for (genvar g = 0; g < 3; g++) begin : g_rate_chk
      localparam int HG = H_FAST << g;
      if (HG < 2 || (BASE_DIV % 2) != 0) begin : g_bad_half
         $error("divided half period %0d is not usable", HG);
      end
   end

   logic              want_div;
   logic [HALF_W-1:0] half_sel;
   logic              use_div;
   logic              div_q;
   logic [HALF_W-1:0] key_q;

   clkout_rate_sel #(
      .HALF_W (HALF_W),
      .H_FAST (H_FAST),
      .H_MID  (H_MID),
      .H_SLOW (H_SLOW)
   ) u_sel (
      .clk_ctrl (clk_ctrl),
      .mod_mode (mod_mode),
      .rate_opt (rate_opt),
      .want_div (want_div),
      .half_sel (half_sel)
   );

   clkout_divider #(.HALF_W(HALF_W)) u_div (
      .clk      (clk_ref),
      .soft_rst (soft_rst),
      .want_div (want_div),
      .half_req (half_sel),
      .use_div  (use_div),
      .div_q    (div_q),
      .key_q    (key_q)
   );

   clkout_switch u_sw (
      .clk      (clk_ref),
      .soft_rst (soft_rst),
      .want_div (want_div),
      .div_q    (div_q),
      .use_div  (use_div),
      .clk_out  (clk_out)
   );

   // R2/R3: the pin is only handed to the divider while a rate is loaded
   a_r2_div_has_rate: assert property (@(posedge clk_ref) disable iff (soft_rst)
      (use_div && div_q) |-> (key_q != '0));
endmodule

// File: tb/tb_modem_clkout_gen.sv
`timescale 1ns/1ps
module tb_modem_clkout_gen;
   localparam int CLK_PERIOD = 10;
   localparam int HALF_P     = CLK_PERIOD / 2;

   logic       clk_ref  = 1'b0;
   logic       soft_rst = 1'b1;
   logic       clk_ctrl = 1'b1;
   logic [1:0] mod_mode = 2'b10;
   logic       rate_opt = 1'b0;
   logic       clk_out;

   int checks = 0;
   int fails  = 0;
   int runt_err = 0;
   bit armed = 1'b0;
   bit done  = 1'b0;
   realtime t_rise = 0.0;
   realtime t_fall = 0.0;

   modem_clkout_gen dut (
      .clk_ref  (clk_ref),
      .soft_rst (soft_rst),
      .clk_ctrl (clk_ctrl),
      .mod_mode (mod_mode),
      .rate_opt (rate_opt),
      .clk_out  (clk_out)
   );

   always #(HALF_P) clk_ref = ~clk_ref;

   // pulse-width monitor for R6
   always @(posedge clk_out) begin
      if (armed && !soft_rst && ($realtime - t_fall) < HALF_P) runt_err++;
      t_rise = $realtime;
   end
   always @(negedge clk_out) begin
      realtime w;
      w = $realtime - t_rise;
      if (armed && !soft_rst &&
          !(w == HALF_P || w == 144.0*CLK_PERIOD ||
            w == 288.0*CLK_PERIOD || w == 576.0*CLK_PERIOD))
         runt_err++;
      t_fall = $realtime;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_half(input logic [1:0] m, input logic o, input logic c);
      if (!c) return 0;
      case (m)
         2'b10:   return 144;
         2'b01:   return o ? 576 : 288;
         default: return 0;
      endcase
   endfunction

   task automatic apply(input logic [1:0] m, input logic o, input logic c);
      @(negedge clk_ref); #1;
      mod_mode = m; rate_opt = o; clk_ctrl = c;
   endtask

   task automatic check_echo(input string req);
      int mism = 0;
      repeat (6) begin
         @(posedge clk_ref); #2;
         if (clk_out !== 1'b1) mism++;
         @(negedge clk_ref); #2;
         if (clk_out !== 1'b0) mism++;
      end
      check(mism == 0, req, "echo mismatches", mism, 0);
   endtask

   task automatic sample_low(output logic v);
      @(negedge clk_ref); #2;
      v = clk_out;
   endtask

   task automatic measure_div(input int h, input string req);
      logic v;
      int guard = 0;
      int hi = 0;
      int lo = 0;
      do begin sample_low(v); guard++; end while (v !== 1'b0 && guard < 6000);
      do begin sample_low(v); guard++; end while (v !== 1'b1 && guard < 6000);
      hi = 1;
      do begin sample_low(v); if (v === 1'b1) hi++; guard++; end
      while (v === 1'b1 && guard < 6000);
      lo = 1;
      do begin sample_low(v); if (v === 1'b0) lo++; guard++; end
      while (v === 1'b0 && guard < 6000);
      check(hi == h, req, "high half period", hi, h);
      check(lo == h, req, "low half period", lo, h);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic v;
      logic p;
      int zeros;
      int guard;
      void'($urandom(32'd2718));

      // R5: reset state, divided clock requested but reset held
      repeat (4) @(posedge clk_ref);
      check_echo("R5");
      apply(2'b10, 1'b0, 1'b1);
      soft_rst = 1'b0;
      armed = 1'b1;

      // R2: QAM, both rate options
      measure_div(144, "R2");
      apply(2'b10, 1'b1, 1'b1);
      measure_div(144, "R2");

      // R3: DPSK rates
      apply(2'b01, 1'b0, 1'b1);
      measure_div(288, "R3");
      apply(2'b01, 1'b1, 1'b1);
      measure_div(576, "R3");

      // R4: FSK and reserved code fall back to echo
      apply(2'b00, 1'b0, 1'b1);
      repeat (1200) @(posedge clk_ref);
      check_echo("R4");
      apply(2'b11, 1'b1, 1'b1);
      repeat (3) @(posedge clk_ref);
      check_echo("R4");

      // R1: control bit low in each mode
      apply(2'b10, 1'b0, 1'b0);
      repeat (3) @(posedge clk_ref);
      check_echo("R1");
      apply(2'b01, 1'b1, 1'b0);
      repeat (3) @(posedge clk_ref);
      check_echo("R1");

      // R7: change rate right at the start of a low phase
      apply(2'b10, 1'b0, 1'b1);
      p = 1'b0; guard = 0;
      do begin p = v; sample_low(v); guard++; end
      while (!(p === 1'b1 && v === 1'b0) && guard < 3000);
      mod_mode = 2'b01; rate_opt = 1'b0;
      zeros = 0; guard = 0;
      do begin sample_low(v); if (v === 1'b0) zeros++; guard++; end
      while (v === 1'b0 && guard < 3000);
      check(zeros == 288, "R7", "low cycles after restart", zeros, 288);

      // R8: change rate just after a rising edge of the divided clock
      p = 1'b1; guard = 0;
      do begin p = v; sample_low(v); guard++; end
      while (!(p === 1'b0 && v === 1'b1) && guard < 3000);
      rate_opt = 1'b1;
      measure_div(576, "R8");

      // R5: reset while the divided clock is running
      apply(2'b10, 1'b0, 1'b1);
      measure_div(144, "R5");
      @(negedge clk_ref); #1;
      soft_rst = 1'b1;
      @(posedge clk_ref);
      check_echo("R5");
      apply(2'b10, 1'b0, 1'b1);
      soft_rst = 1'b0;
      measure_div(144, "R5");

      // random mix, R1..R4 and R8 transitions
      for (int i = 0; i < 12; i++) begin
         logic [1:0] m;
         logic o;
         logic c;
         int h;
         m = 2'($urandom % 4);
         o = 1'($urandom % 2);
         c = 1'($urandom % 4 != 0);
         h = exp_half(m, o, c);
         apply(m, o, c);
         if (h == 0) begin
            repeat (1160) @(posedge clk_ref);
            check_echo(c ? "R4" : "R1");
         end else begin
            measure_div(h, (m == 2'b10) ? "R2" : "R3");
         end
      end

      // R6: no runt or misshapen pulse seen anywhere
      check(runt_err == 0, "R6", "bad pulse widths", runt_err, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule